// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block controls a five-input, 8-bit analog-to-digital converter from a small register bus. Software writes a control byte to pick an input, enable the converter and request a conversion. The block then counts machine-cycle ticks through a fixed conversion window. At the end of the window it captures the converter's 8-bit output into a result register and raises a completion flag. The flag gates an interrupt request and stays set until the result register is read.

While a conversion runs, or while a result waits to be read, new start requests are dropped and the input selection is locked. Entering idle or power-down cancels a running conversion, but a finished result survives. A mask stage sits between the port pins and the digital read path. While the converter is enabled, it forces the selected pin to read as 1.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 (converter disabled, idle, input 0), the result register reads 0x00 and the interrupt request is low.
- R2: Control register layout: bits 2:0 hold the input select, bit 3 is the busy bit, bit 4 is the done flag and bit 5 is the enable bit. Bits 7:6 read as 0. A write with bit 3 set, made while busy and done are both 0, sets busy, so the status {done,busy} reads 01.
- R3: Once a start is accepted, the conversion completes on exactly the 40th machine-cycle tick. Clock cycles without a tick do not advance it.
- R4: On the completing tick, busy clears, done sets and the sample input is captured into the result register (address 1), all on the same edge.
- R5: A start request made while busy or done is 1 is discarded. Writing 0 to bit 3 cannot end a running conversion, and the running conversion still completes on its 40th tick.
- R6: The done flag is read-only. Only a read of the result register clears it; reading the control register leaves it set.
- R7: The input select field takes a written value only while busy and done are both 0. Otherwise writes to that field are discarded.
- R8: The interrupt request is high exactly when done is 1 and the interrupt-enable input is 1.
- R9: While busy, an active idle or power-down input aborts the conversion and returns the status to 00 with the result unchanged. A done flag that is already set stays set through idle. A start request made while either mode input is active is discarded.
- R10: While enable is 1, the masked digital read of the selected input pin returns 1. All other pins, and every pin while enable is 0, return their true level.
- R11: Input select codes 5, 6 and 7 are invalid. A start request carrying one of them is discarded, while the code itself is still stored.
- R12: The enable bit follows the written bit 5 and reads back unchanged. The enable bit does not gate the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide per cycle |
| idle_mode | input | 1 | Idle mode active |
| pd_mode | input | 1 | Power-down mode active |
| reg_addr | input | 1 | Register select: 0 control, 1 result |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of the result clears done |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_en | input | 1 | Converter interrupt enable |
| irq | output | 1 | Interrupt request |
| sample_in | input | 8 | Converter output, captured at completion |
| chan_sel | output | 3 | Input select to the analog multiplexer |
| pin_in | input | 5 | True levels of the five shared pins |
| pin_rd | output | 5 | Masked digital read of the five pins |

## Verification
Any corruption of busy, done or the tick count appears at once in the status bits of the control register. It then shows as an early or late completion, counted to the exact tick, or as a start that was wrongly accepted or wrongly dropped. A done flag that clears too early shows on the interrupt output in the same cycle. A select field that drifts changes chan_sel and the masked pin pattern one cycle after the write that should have been discarded. The bench therefore samples the status after each tick boundary, around the 39th and 40th ticks, and after every blocked write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // control register bit positions (software-visible layout)
  localparam int SEL_LSB  = 0;
  localparam int BUSY_BIT = 3;
  localparam int DONE_BIT = 4;
  localparam int EN_BIT   = 5;

  // register addresses
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_RES  = 1'b1;

  // an input code is usable only below the channel count
  function automatic logic sel_valid(input logic [2:0] code, input int nch);
    return int'(code) < nch;
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic en, input logic done,
                                           input logic busy, input logic [2:0] sel);
    logic [7:0] v;
    v = 8'h00;
    v[EN_BIT]   = en;
    v[DONE_BIT] = done;
    v[BUSY_BIT] = busy;
    v[SEL_LSB +: 3] = sel;
    return v;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CONV_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic last
);
  localparam int CW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(CONV_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign last = run && tick && (cnt_q == LAST_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (run && tick)   cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_pinmask.sv
module adc_seq_pinmask #(
  parameter int NCH = 5,
  parameter int AW  = 3
) (
  input  logic           en,
  input  logic [AW-1:0]  sel,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_rd
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pin_rd[i] = (en && (sel == AW'(i))) ? 1'b1 : pin_in[i];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH        = 5,
  parameter int DW         = 8,
  parameter int CONV_TICKS = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           idle_mode,
  input  logic           pd_mode,
  input  logic           reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           irq_en,
  output logic           irq,
  input  logic [DW-1:0]  sample_in,
  output logic [2:0]     chan_sel,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_rd
);
  import adc_seq_pkg::*;

  localparam int AW = 3;

  logic          en_q, busy_q, done_q;
  logic [AW-1:0] sel_q;
  logic [DW-1:0] res_q;

  // named internal events
  logic ctrl_wr, result_rd, low_power, sel_open;
  logic start_req, start_ok, conv_done, conv_abort, timer_last;
  logic [AW-1:0] sel_wr;
  logic unused_wbits;

  assign unused_wbits = &{1'b0, reg_wdata[7:6]};

  assign ctrl_wr    = reg_wr && (reg_addr == ADDR_CTRL);
  assign result_rd  = reg_rd && (reg_addr == ADDR_RES);
  assign low_power  = idle_mode || pd_mode;
  assign sel_open   = !busy_q && !done_q;
  assign sel_wr     = reg_wdata[SEL_LSB +: AW];
  assign start_req  = ctrl_wr && reg_wdata[BUSY_BIT];
  assign start_ok   = start_req && sel_open && !low_power && sel_valid(sel_wr, NCH);
  assign conv_done  = busy_q && timer_last && !low_power;
  assign conv_abort = busy_q && low_power;

  adc_seq_timer #(.CONV_TICKS(CONV_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_ok || !busy_q),
    .run   (busy_q),
    .tick  (tick),
    .last  (timer_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= '0;
      res_q  <= '0;
    end else begin
      if (ctrl_wr) en_q <= reg_wdata[EN_BIT];
      if (ctrl_wr && sel_open) sel_q <= sel_wr;

      if (start_ok)                      busy_q <= 1'b1;
      else if (conv_done || conv_abort)  busy_q <= 1'b0;

      if (conv_done)      done_q <= 1'b1;
      else if (result_rd) done_q <= 1'b0;

      if (conv_done) res_q <= sample_in;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_RES) reg_rdata = 8'(res_q);
    else                      reg_rdata = pack_ctrl(en_q, done_q, busy_q, sel_q);
  end

  assign irq      = done_q && irq_en;
  assign chan_sel = sel_q;

  adc_seq_pinmask #(.NCH(NCH), .AW(AW)) u_mask (
    .en     (en_q),
    .sel    (sel_q),
    .pin_in (pin_in),
    .pin_rd (pin_rd)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NCH        = 5,
  parameter int DW         = 8,
  parameter int CONV_TICKS = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          busy,
  input logic          done,
  input logic          low_power,
  input logic          conv_done,
  input logic          result_rd,
  input logic [2:0]    chan_sel,
  input logic [DW-1:0] res
);
  // ticks seen in the current conversion, counted independently
  int unsigned tk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tk_cnt <= 0;
    else if (!busy)         tk_cnt <= 0;
    else if (tick)          tk_cnt <= tk_cnt + 1;
  end

  p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (tick && tk_cnt == CONV_TICKS - 1));

  p_finish_sets_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (done && !busy));

  p_result_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(res));

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !low_power && !conv_done) |=> busy);

  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result_rd) |=> done);

  p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> $stable(chan_sel));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && low_power) |=> (!busy && !done));

  p_sel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(chan_sel) < NCH));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NCH(NCH), .DW(DW), .CONV_TICKS(CONV_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .busy      (busy_q),
  .done      (done_q),
  .low_power (low_power),
  .conv_done (conv_done),
  .result_rd (result_rd),
  .chan_sel  (chan_sel),
  .res       (res_q)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, idle_mode = 0, pd_mode = 0;
  logic reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_en = 0, irq;
  logic [7:0] sample_in = 0;
  logic [2:0] chan_sel;
  logic [4:0] pin_in = 0, pin_rd;

  int n_cmp = 0, n_bad = 0;
  bit  done_flag = 0;

  always #2 clk = ~clk;   // 250 MHz

  adc_seq_ctrl u0 (.*);

  // {sel[16:14], sample[13:6], irq_en[5], pins[4:0]}
  localparam logic [16:0] VEC [4] = '{
    {3'd0, 8'hA5, 1'b1, 5'b00000},
    {3'd4, 8'h3C, 1'b0, 5'b01010},
    {3'd2, 8'hFF, 1'b1, 5'b11011},
    {3'd1, 8'h00, 1'b0, 5'b10101}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); reg_addr = 0; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_result(output logic [7:0] d);
    @(negedge clk); reg_addr = 1; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic mode_pulse(input bit use_pd);
    @(negedge clk); if (use_pd) pd_mode = 1; else idle_mode = 1;
    @(negedge clk); pd_mode = 0; idle_mode = 0;
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(0, d); check("R1 ctrl", d, 8'h00);
    peek(1, d); check("R1 result", d, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    pin_in = 5'b00110; #1;
    check("R10 disabled pins", {3'b0, pin_rd}, 8'h06);

    // R12 enable bit
    wr_ctrl(8'h20); peek(0, d); check("R12 enable set", d, 8'h20);
    wr_ctrl(8'h00); peek(0, d); check("R12 enable clear", d, 8'h00);

    // table walk: R2 R3 R4 R8 R10
    for (int k = 0; k < 4; k++) begin
      logic [2:0] s; logic [7:0] smp; logic [4:0] pins;
      s = VEC[k][16:14]; smp = VEC[k][13:6]; pins = VEC[k][4:0];
      sample_in = smp; irq_en = VEC[k][5]; pin_in = pins;
      wr_ctrl(8'h28 | {5'b0, s});
      peek(0, d); check("R2 busy status", d, 8'h28 | {5'b0, s});
      check("R10 masked pins", {3'b0, pin_rd}, {3'b0, pins | (5'b1 << s)});
      check("R2 chan_sel", {5'b0, chan_sel}, {5'b0, s});
      run_ticks(39);
      peek(0, d); check("R3 still busy at 39", d, 8'h28 | {5'b0, s});
      run_ticks(1);
      peek(0, d); check("R4 done at 40", d, 8'h30 | {5'b0, s});
      check("R8 irq", {7'b0, irq}, {7'b0, VEC[k][5]});
      rd_result(d); check("R4 result", d, smp);
      peek(0, d); check("R6 cleared by read", d, 8'h20 | {5'b0, s});
      check("R8 irq low", {7'b0, irq}, 8'h00);
    end

    // R3 cycles without tick do not advance
    sample_in = 8'h5A; irq_en = 1;
    wr_ctrl(8'h09);
    repeat (60) @(negedge clk);
    peek(0, d); check("R3 no tick no progress", d, 8'h09);
    // R5 start ignored while busy, software cannot clear busy; R7 sel frozen
    run_ticks(10);
    wr_ctrl(8'h0B);
    peek(0, d); check("R5 R7 busy restart ignored", d, 8'h09);
    wr_ctrl(8'h01);
    peek(0, d); check("R5 busy not clearable", d, 8'h09);
    run_ticks(29);
    peek(0, d); check("R5 still busy at 39", d, 8'h09);
    run_ticks(1);
    peek(0, d); check("R5 completes at 40", d, 8'h11);
    wr_ctrl(8'h0C);
    peek(0, d); check("R5 R7 start while done dropped", d, 8'h10 | 8'h01);
    check("R7 chan_sel held", {5'b0, chan_sel}, 8'h01);
    // R6 control read and idle do not clear done; R9 done survives idle
    peek(0, d); peek(0, d); check("R6 ctrl read keeps done", d, 8'h11);
    mode_pulse(0);
    peek(0, d); check("R9 done kept in idle", d, 8'h11);
    check("R8 irq high", {7'b0, irq}, 8'h01);
    irq_en = 0; #1;
    check("R8 irq gated", {7'b0, irq}, 8'h00);
    rd_result(d); check("R6 result value", d, 8'h5A);
    peek(0, d); check("R6 done cleared", d, 8'h01);

    // R9 abort by idle and by power-down, start blocked in low power
    wr_ctrl(8'h0A); run_ticks(5);
    mode_pulse(0);
    peek(0, d); check("R9 idle abort", d, 8'h02);
    wr_ctrl(8'h0A); run_ticks(5);
    mode_pulse(1);
    peek(0, d); check("R9 pd abort", d, 8'h02);
    peek(1, d); check("R9 result untouched", d, 8'h5A);
    @(negedge clk); idle_mode = 1; reg_addr = 0; reg_wr = 1; reg_wdata = 8'h0A;
    @(negedge clk); reg_wr = 0; idle_mode = 0;
    peek(0, d); check("R9 start blocked in idle", d, 8'h02);

    // R11 invalid codes
    for (int c = 5; c < 8; c++) begin
      wr_ctrl(8'h08 | 8'(c));
      peek(0, d); check("R11 invalid code rejected", d, 8'(c));
    end

    done_flag = 1;
    report();
  end
endmodule